// File: doc/BRIEF.md
# Switched Analysis Unit Health Supervisor

This block supervises a power-switched image-analysis unit. A higher level sends single-cycle requests to turn the unit on or off. The supervisor keeps a one-bit record of the most recent request, called the enable memory. It drives the unit's switch with a voltage command that follows this memory.

On every cycle the supervisor receives three observations from the unit: a supply-voltage bit, a current bit and a two-bit analysis result. It compares these against each other and against the enable memory. From the previous cycle's values it reports three registered status bits: running, failing and hot spot detected. The higher level uses them to tell a healthy, powered unit apart from one whose switch, circuit or analyzer is misbehaving.

Top module: `unit_health_sup`

## Requirements
- R1: While the synchronous active-high reset is asserted, and in the first cycle after it, the outputs `volt_cmd`, `running`, `failing` and `hot_spot` are all 0.
- R2: An on pulse makes the enable memory 1 from the next cycle. An off pulse makes it 0 from the next cycle. With neither pulse it keeps its value. The two pulses never arrive together.
- R3: `volt_cmd` always equals the enable memory, so it changes one cycle after the request pulse.
- R4: `failing` is 1 in a cycle exactly when, in the previous cycle, at least one of these held: the observed voltage differed from the enable memory; the observed current differed from the observed voltage; the enable memory was 1 and the analysis result was none.
- R5: `running` is 1 exactly when, in the previous cycle, the enable memory, voltage and current were all 1, the analysis result was normal (01) or hot spot (10), and `failing` is 0.
- R6: `running` and `failing` are never both 1. When the enable memory was 1 in the previous cycle, exactly one of them is 1.
- R7: `hot_spot` is 1 exactly when `running` is 1 and the previous cycle's analysis result was hot spot (10).
- R8: The analysis code 11 behaves exactly like none (00) for every output.
- R9: When, in the previous cycle, the enable memory was 0 and voltage and current were both 0, then `running`, `failing` and `hot_spot` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| on_req | input | 1 | Single-cycle request to power the unit |
| off_req | input | 1 | Single-cycle request to unpower the unit |
| volt_obs | input | 1 | Observed supply voltage in the unit |
| curr_obs | input | 1 | Observed current in the unit |
| result_in | input | 2 | Analysis result: 00 none, 01 normal, 10 hot spot, 11 none |
| volt_cmd | output | 1 | Voltage command to the unit's switch |
| running | output | 1 | Unit is on and healthy |
| failing | output | 1 | An inconsistency was seen |
| hot_spot | output | 1 | Running and a hot spot was reported |

## Verification
The bench sweeps all sixteen combinations of voltage, current and analysis code. It applies them with the enable memory both at 0 and at 1, and interleaves on pulses, off pulses and idle cycles so that the memory changes during the sweep. The sweep with the memory at 0 separates an idle unit from one that has stuck voltage or leaking current. The sweep with the memory at 1 separates running from failing on each of the three mismatch causes on its own. The hot spot and code 11 cases show that the analysis code is decoded correctly, and the request pattern shows set, clear and hold of the memory together with the one-cycle lag of the voltage command.

// File: rtl/hsup_pkg.sv
package hsup_pkg;
    localparam int RES_W = 2;

    typedef enum logic [RES_W-1:0] {
        RES_NONE   = 2'b00,
        RES_NORMAL = 2'b01,
        RES_HOT    = 2'b10,
        RES_RSVD   = 2'b11
    } res_e;

    typedef struct packed {
        logic sw;
        logic volt;
        logic curr;
        res_e res;
    } obs_t;

    typedef struct packed {
        logic running;
        logic failing;
        logic hot;
    } status_t;

    function automatic logic res_present(res_e r);
        return (r == RES_NORMAL) || (r == RES_HOT);
    endfunction
endpackage

// File: rtl/hsup_req_mem.sv
module hsup_req_mem (
    input  logic clk,
    input  logic rst,
    input  logic on_req,
    input  logic off_req,
    output logic sw_q
);
    always_ff @(posedge clk) begin
        if (rst)          sw_q <= 1'b0;
        else if (on_req)  sw_q <= 1'b1;
        else if (off_req) sw_q <= 1'b0;
    end
endmodule

// File: rtl/hsup_classify.sv
module hsup_classify
    import hsup_pkg::*;
(
    input  obs_t    obs,
    output status_t stat
);
    logic mismatch;
    logic healthy;

    always_comb begin
        mismatch = (obs.volt != obs.sw)
                 | (obs.curr != obs.volt)
                 | (obs.sw & ~res_present(obs.res));
        healthy  = obs.sw & obs.volt & obs.curr & res_present(obs.res) & ~mismatch;
        stat.failing = mismatch;
        stat.running = healthy;
        stat.hot     = healthy & (obs.res == RES_HOT);
    end
endmodule

// File: rtl/unit_health_sup.sv
module unit_health_sup
    import hsup_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             on_req,
    input  logic             off_req,
    input  logic             volt_obs,
    input  logic             curr_obs,
    input  logic [RES_W-1:0] result_in,
    output logic             volt_cmd,
    output logic             running,
    output logic             failing,
    output logic             hot_spot
);
    logic    sw_q;
    obs_t    obs_now;
    status_t stat_next;
    status_t stat_q;

    hsup_req_mem u_mem (
        .clk     (clk),
        .rst     (rst),
        .on_req  (on_req),
        .off_req (off_req),
        .sw_q    (sw_q)
    );

    always_comb begin
        obs_now.sw   = sw_q;
        obs_now.volt = volt_obs;
        obs_now.curr = curr_obs;
        obs_now.res  = res_e'(result_in);
    end

    hsup_classify u_cls (
        .obs  (obs_now),
        .stat (stat_next)
    );

    always_ff @(posedge clk) begin
        if (rst) stat_q <= '0;
        else     stat_q <= stat_next;
    end

    assign volt_cmd = sw_q;
    assign running  = stat_q.running;
    assign failing  = stat_q.failing;
    assign hot_spot = stat_q.hot;
endmodule

// File: rtl/unit_health_sup_chk.sv
module unit_health_sup_chk (
    input logic       clk,
    input logic       rst,
    input logic       on_req,
    input logic       off_req,
    input logic       volt_obs,
    input logic       curr_obs,
    input logic [1:0] result_in,
    input logic       volt_cmd,
    input logic       running,
    input logic       failing,
    input logic       hot_spot
);
    logic seen;
    always_ff @(posedge clk) begin
        if (rst) seen <= 1'b0;
        else     seen <= 1'b1;
    end

    p_mutex_r6: assert property (@(posedge clk) disable iff (rst)
        !(running && failing));

    p_one_when_on_r6: assert property (@(posedge clk) disable iff (rst)
        (seen && volt_cmd) |=> $countones({running, failing}) == 1);

    p_set_r2: assert property (@(posedge clk) disable iff (rst)
        on_req |=> volt_cmd);

    p_clear_r2: assert property (@(posedge clk) disable iff (rst)
        off_req |=> !volt_cmd);

    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (seen && !on_req && !off_req) |=> $stable(volt_cmd));

    p_hot_needs_run_r7: assert property (@(posedge clk) disable iff (rst)
        hot_spot |-> running);

    p_fail_cause_r4: assert property (@(posedge clk) disable iff (rst)
        (seen && (volt_obs != curr_obs)) |=> failing);

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        (seen && !volt_cmd && !volt_obs && !curr_obs) |=> !running && !failing && !hot_spot);
endmodule

bind unit_health_sup unit_health_sup_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .on_req    (on_req),
    .off_req   (off_req),
    .volt_obs  (volt_obs),
    .curr_obs  (curr_obs),
    .result_in (result_in),
    .volt_cmd  (volt_cmd),
    .running   (running),
    .failing   (failing),
    .hot_spot  (hot_spot)
);

// File: tb/unit_health_sup_tb.sv
module unit_health_sup_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       on_req = 1'b0;
    logic       off_req = 1'b0;
    logic       volt_obs = 1'b0;
    logic       curr_obs = 1'b0;
    logic [1:0] result_in = 2'b00;
    logic       volt_cmd, running, failing, hot_spot;

    int n_chk = 0;
    int n_fail = 0;
    logic model_sw = 1'b0;
    logic done = 1'b0;

    always #5 clk = ~clk;

    unit_health_sup dut_i (
        .clk(clk), .rst(rst), .on_req(on_req), .off_req(off_req),
        .volt_obs(volt_obs), .curr_obs(curr_obs), .result_in(result_in),
        .volt_cmd(volt_cmd), .running(running), .failing(failing),
        .hot_spot(hot_spot)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b time=%0t", req, act, exp, $time);
        end
    endtask

    // Drive one cycle of stimulus and check the registered response.
    task automatic step(input logic on_p, input logic off_p,
                        input logic v, input logic c, input logic [1:0] r);
        logic valid, mis, e_run, e_fail, e_hot, nxt;
        on_req = on_p; off_req = off_p;
        volt_obs = v; curr_obs = c; result_in = r;
        valid  = (r == 2'b01) || (r == 2'b10);
        mis    = (v != model_sw) || (c != v) || (model_sw && !valid);
        e_fail = mis;
        e_run  = model_sw && v && c && valid && !mis;
        e_hot  = e_run && (r == 2'b10);
        nxt    = on_p ? 1'b1 : (off_p ? 1'b0 : model_sw);
        @(negedge clk);
        chk("R2 memory", volt_cmd, nxt);
        chk("R3 volt_cmd", volt_cmd, nxt);
        chk("R4 failing", failing, e_fail);
        chk("R5 running", running, e_run);
        chk("R6 exclusive", running & failing, 1'b0);
        if (model_sw) chk("R6 exactly one", running ^ failing, 1'b1);
        chk("R7 hot_spot", hot_spot, e_hot);
        if (r == 2'b11) chk("R8 code 11 as none", running, 1'b0);
        if (!model_sw && !v && !c)
            chk("R9 idle quiet", running | failing | hot_spot, 1'b0);
        model_sw = nxt;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset volt_cmd", volt_cmd, 1'b0);
        chk("R1 reset running", running, 1'b0);
        chk("R1 reset failing", failing, 1'b0);
        chk("R1 reset hot_spot", hot_spot, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 first cycle", volt_cmd | running | failing | hot_spot, 1'b0);

        // Sweep all observations with memory 0 and 1, mixing requests.
        for (int s = 0; s < 2; s++) begin
            if (s == 1) step(1'b1, 1'b0, 1'b0, 1'b0, 2'b00);
            else        step(1'b0, 1'b1, 1'b0, 1'b0, 2'b00);
            for (int k = 0; k < 16; k++) begin
                step(1'b0, 1'b0, k[3], k[2], k[1:0]);
            end
        end
        // Requests interleaved with a changing sweep.
        for (int k = 0; k < 48; k++) begin
            int q = k % 3;
            step(q == 1, q == 2, k[3], k[2], k[1:0]);
        end
        // Healthy hot spot followed by code 11, then off.
        step(1'b1, 1'b0, 1'b0, 1'b0, 2'b00);
        step(1'b0, 1'b0, 1'b1, 1'b1, 2'b10);
        step(1'b0, 1'b0, 1'b1, 1'b1, 2'b11);
        step(1'b0, 1'b1, 1'b1, 1'b1, 2'b01);
        step(1'b0, 1'b0, 1'b0, 1'b0, 2'b00);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_chk++;
                n_fail++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule